// File: doc/BRIEF.md
# Cache Miss-Buffer Admission and Stall Controller

This block decides whether a cache may place a new entry in one of its two small tracking queues. One queue holds outstanding misses and the other holds pending writebacks. Cache control logic asks for an entry in either queue. One cycle later it gets back a slot index and a sequence number, or an error if the queue was full. Control logic frees entries by marking them in service. Each queue keeps a bitmap of busy slots and always hands out the free slot with the lowest index.

A small bitmask records why the cache cannot accept new CPU traffic. Bit 0 means the miss queue is full, bit 1 means the write buffer is full, and bit 2 means a miss entry has run out of target slots; that last cause is set and cleared from outside. A state machine with two states drives one stall line toward the CPU side:

- `STALL_OPEN` is the reset state. It moves to `STALL_HELD` on the edge at which the mask becomes non-zero. That edge counts one stall event against the cause that set it and stamps the current cycle.
- `STALL_HELD` moves back to `STALL_OPEN` on the edge at which the mask becomes zero. The elapsed cycles are added to the counter of the cause whose clearing released the stall.

An accepted allocation can also request the memory-side bus, tagged with a cause code. A separate countdown flags when a set number of misses has been reached.

Top module: `cache_admit_ctrl`

## Requirements
- R1: After reset `cpu_blocked`, `block_mask`, all stall event and stall cycle counters, `resp_valid`, `bus_req_valid` and `miss_limit_hit` are 0, and both queues are empty.
- R2: An allocation presented on an edge is answered by `resp_valid` one cycle later.
  - An accepted allocation returns the lowest free slot of the selected queue (`alloc_sel` 0 = miss queue, 1 = write buffer).
  - An allocation into a full queue returns `resp_err`=1 and changes no slot.
- R3: `resp_seq` comes from one counter shared by both queues. It starts at 0 and advances by one per accepted allocation only.
- R4: Address and length of the response depend on the queue.
  - A miss-queue response carries the address rounded down to a multiple of `BLK_BYTES` and a length of `BLK_BYTES`.
  - A write-buffer response carries the request address and `alloc_size` unchanged.
- R5: An allocation that fills a queue sets mask bit 0 (miss queue) or bit 1 (write buffer) on the same edge.
- R6: Marking a busy slot of a full queue in service clears that queue's mask bit on the same edge. Marking a free slot in service changes nothing.
- R7: `cpu_blocked` equals 1 exactly while `block_mask` is non-zero. Entering the stall adds one to `stall_events[c]` for the setting cause c.
- R8: Leaving the stall adds the number of cycles `cpu_blocked` was high to `stall_cycles[c]`, where c is the cause whose clearing emptied the mask. This holds even if a different cause started the stall.
- R9: Setting a cause already set, or clearing one already clear, leaves the mask, the counters and `cpu_blocked` unchanged.
- R10: An accepted allocation with `alloc_want_bus`=1 pulses `bus_req_valid` one cycle later with cause 0 (miss) or 1 (writeback). A lone `pf_bus_req` gives cause 2. An allocation request takes priority over a prefetch request on the same edge. No request is raised on an edge where `retry_pending`=1.
- R11: Each `miss_event` decrements a counter loaded with `MISS_LIMIT` while it is non-zero. The event that brings it to zero pulses `miss_limit_hit` for exactly one cycle. Later events produce nothing, and `MISS_LIMIT`=0 disables the pulse.
- R12: When several causes set the mask from zero on one edge, the event is counted for the lowest-numbered cause. When several causes clear it to zero on one edge, the cycles are charged to the lowest-numbered cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_sel | input | 1 | Target queue: 0 miss, 1 write buffer |
| alloc_addr | input | ADDR_W | Request address |
| alloc_size | input | LEN_W | Request size (write buffer) |
| alloc_want_bus | input | 1 | Raise a memory-side bus request on acceptance |
| svc_valid | input | 1 | Mark an entry in service |
| svc_sel | input | 1 | Queue of the in-service entry |
| svc_slot | input | SLOT_W | Slot of the in-service entry |
| tgt_stall_set | input | 1 | Set cause 2 (no target slots) |
| tgt_stall_clr | input | 1 | Clear cause 2 |
| pf_bus_req | input | 1 | Prefetch bus request |
| retry_pending | input | 1 | A bus retry is outstanding |
| miss_event | input | 1 | One miss occurred |
| resp_valid | output | 1 | Allocation response valid |
| resp_err | output | 1 | Allocation rejected, queue full |
| resp_sel | output | 1 | Queue of the response |
| resp_slot | output | SLOT_W | Granted slot |
| resp_seq | output | SEQ_W | Sequence number |
| resp_addr | output | ADDR_W | Entry address |
| resp_len | output | LEN_W | Entry length |
| bus_req_valid | output | 1 | Memory-side bus request pulse |
| bus_req_cause | output | 2 | Bus request cause: 0 miss, 1 writeback, 2 prefetch |
| cpu_blocked | output | 1 | Stall toward the CPU side |
| block_mask | output | NUM_CAUSE | Per-cause blocked bits |
| stall_events | output | NUM_CAUSE x STAT_W | Stall entries per cause |
| stall_cycles | output | NUM_CAUSE x STAT_W | Stalled cycles per cause |
| miss_limit_hit | output | 1 | Miss countdown reached zero |

## Verification
The bench targets the cause hand-off. It swaps the miss-full cause for the target cause on one edge and then clears the target cause. A design that charged the cause that started the stall would add the cycles to cause 0 instead of cause 2. It sets and clears two causes together to expose a wrong tie-break, and it repeats sets and clears so that a design that counted every set would show extra stall events. It marks a free slot in service and then refills a queue to catch wrong slot choice or a spurious unblock. It also drives a bus request while a retry is outstanding, and a prefetch and an allocation together.

// File: rtl/cache_admit_pkg.sv
package cache_admit_pkg;

    localparam int NUM_CAUSE = 3;

    typedef enum logic [1:0] {
        CAUSE_MISS_FULL = 2'd0,
        CAUSE_WB_FULL   = 2'd1,
        CAUSE_TGT_FULL  = 2'd2
    } block_cause_e;

    typedef enum logic [1:0] {
        BUSC_MISS = 2'd0,
        BUSC_WB   = 2'd1,
        BUSC_PF   = 2'd2
    } bus_cause_e;

    typedef enum logic {
        STALL_OPEN = 1'b0,
        STALL_HELD = 1'b1
    } stall_state_e;

endpackage

// File: rtl/alloc_queue.sv
module alloc_queue #(
    parameter int DEPTH  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              rel_req,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              accept,
    output logic [SLOT_W-1:0] grant_slot,
    output logic              becomes_full,
    output logic              leaves_full
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] busy_q;
    logic [DEPTH-1:0] busy_d;
    logic [IW-1:0]    grant_idx;
    logic [IW-1:0]    rel_idx;
    logic             full_now;
    logic             rel_ok;

    assign full_now = &busy_q;
    assign accept   = alloc_req && !full_now;
    assign rel_idx  = rel_slot[IW-1:0];
    assign rel_ok   = rel_req && (int'(rel_slot) < DEPTH) && busy_q[rel_idx];

    // lowest free slot: scan from the top so the smallest index wins
    always_comb begin
        grant_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy_q[i]) grant_idx = IW'(i);
        end
    end

    assign grant_slot = SLOT_W'(grant_idx);

    always_comb begin
        busy_d = busy_q;
        if (accept) busy_d[grant_idx] = 1'b1;
        if (rel_ok) busy_d[rel_idx]   = 1'b0;
    end

    assign becomes_full = !full_now && (&busy_d);
    assign leaves_full  = full_now && !(&busy_d);

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_q[$past(grant_idx)]); // R2
    AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && full_now && !rel_req) |=> $stable(busy_q)); // R2

endmodule

// File: rtl/stall_tracker.sv
module stall_tracker import cache_admit_pkg::*; #(
    parameter int NC     = NUM_CAUSE,
    parameter int STAT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NC-1:0]              set_vec,
    input  logic [NC-1:0]              clr_vec,
    output logic [NC-1:0]              mask,
    output logic                       blocked,
    output logic [NC-1:0][STAT_W-1:0]  evt_cnt,
    output logic [NC-1:0][STAT_W-1:0]  cyc_cnt
);
    localparam int CIW = (NC > 1) ? $clog2(NC) : 1;

    stall_state_e              state_q, state_d;
    logic [NC-1:0]             mask_q, mask_d;
    logic [NC-1:0]             rel_vec;
    logic [CIW-1:0]            enter_idx, leave_idx;
    logic                      enter, leave;
    logic [STAT_W-1:0]         now_q, start_q;
    logic [NC-1:0][STAT_W-1:0] evt_q, cyc_q;

    assign mask_d  = (mask_q & ~clr_vec) | set_vec;
    assign rel_vec = mask_q & clr_vec;

    always_comb begin
        enter_idx = '0;
        leave_idx = '0;
        for (int c = NC - 1; c >= 0; c--) begin
            if (mask_d[c])  enter_idx = CIW'(c);
            if (rel_vec[c]) leave_idx = CIW'(c);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        enter   = 1'b0;
        leave   = 1'b0;
        unique case (state_q)
            STALL_OPEN: if (|mask_d) begin
                state_d = STALL_HELD;
                enter   = 1'b1;
            end
            STALL_HELD: if (~|mask_d) begin
                state_d = STALL_OPEN;
                leave   = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= STALL_OPEN;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q   <= '0;
            start_q <= '0;
            evt_q   <= '0;
            cyc_q   <= '0;
        end else begin
            now_q <= now_q + STAT_W'(1);
            if (enter) begin
                start_q          <= now_q;
                evt_q[enter_idx] <= evt_q[enter_idx] + STAT_W'(1);
            end
            if (leave) cyc_q[leave_idx] <= cyc_q[leave_idx] + (now_q - start_q);
        end
    end

    // outputs
    always_comb begin
        blocked = (state_q == STALL_HELD);
        mask    = mask_q;
        evt_cnt = evt_q;
        cyc_cnt = cyc_q;
    end

    AST_HELD_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        blocked == (mask_q != '0)); // R7
    AST_EVT_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> $stable(evt_q)); // R9
    AST_CYC_ONLY_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !blocked |=> $stable(cyc_q)); // R8

endmodule

// File: rtl/miss_countdown.sv
module miss_countdown #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic miss_event,
    output logic hit
);
    localparam int CW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;

    logic [CW-1:0] left_q;
    logic          hit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= CW'(LIMIT);
            hit_q  <= 1'b0;
        end else if (miss_event && (left_q != '0)) begin
            left_q <= left_q - CW'(1);
            hit_q  <= (left_q == CW'(1));
        end else begin
            hit_q  <= 1'b0;
        end
    end

    assign hit = hit_q;

    AST_LIMIT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |=> !hit_q); // R11

endmodule

// File: rtl/cache_admit_ctrl.sv
module cache_admit_ctrl import cache_admit_pkg::*; #(
    parameter int DEPTH_MISS = 4,
    parameter int DEPTH_WB   = 4,
    parameter int BLK_BYTES  = 16,
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 8,
    parameter int SEQ_W      = 8,
    parameter int STAT_W     = 16,
    parameter int MISS_LIMIT = 5,
    localparam int MAXD      = (DEPTH_MISS > DEPTH_WB) ? DEPTH_MISS : DEPTH_WB,
    localparam int SLOT_W    = (MAXD > 1) ? $clog2(MAXD) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_valid,
    input  logic                             alloc_sel,
    input  logic [ADDR_W-1:0]                alloc_addr,
    input  logic [LEN_W-1:0]                 alloc_size,
    input  logic                             alloc_want_bus,
    input  logic                             svc_valid,
    input  logic                             svc_sel,
    input  logic [SLOT_W-1:0]                svc_slot,
    input  logic                             tgt_stall_set,
    input  logic                             tgt_stall_clr,
    input  logic                             pf_bus_req,
    input  logic                             retry_pending,
    input  logic                             miss_event,
    output logic                             resp_valid,
    output logic                             resp_err,
    output logic                             resp_sel,
    output logic [SLOT_W-1:0]                resp_slot,
    output logic [SEQ_W-1:0]                 resp_seq,
    output logic [ADDR_W-1:0]                resp_addr,
    output logic [LEN_W-1:0]                 resp_len,
    output logic                             bus_req_valid,
    output logic [1:0]                       bus_req_cause,
    output logic                             cpu_blocked,
    output logic [NUM_CAUSE-1:0]             block_mask,
    output logic [NUM_CAUSE-1:0][STAT_W-1:0] stall_events,
    output logic [NUM_CAUSE-1:0][STAT_W-1:0] stall_cycles,
    output logic                             miss_limit_hit
);
    localparam int NQ = 2;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(BLK_BYTES - 1);
    localparam int OFF_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;

    logic [NQ-1:0]             q_alloc, q_rel, q_accept, q_fill, q_drain;
    logic [NQ-1:0][SLOT_W-1:0] q_grant;
    logic                      accepted;
    logic [NUM_CAUSE-1:0]      set_vec, clr_vec;
    logic [SEQ_W-1:0]          seq_q;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        localparam int DEP = (q == 0) ? DEPTH_MISS : DEPTH_WB;
        assign q_alloc[q] = alloc_valid && (alloc_sel == q[0]);
        assign q_rel[q]   = svc_valid && (svc_sel == q[0]);
        alloc_queue #(.DEPTH(DEP), .SLOT_W(SLOT_W)) u_queue (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_req    (q_alloc[q]),
            .rel_req      (q_rel[q]),
            .rel_slot     (svc_slot),
            .accept       (q_accept[q]),
            .grant_slot   (q_grant[q]),
            .becomes_full (q_fill[q]),
            .leaves_full  (q_drain[q])
        );
    end

    assign accepted = |q_accept;
    assign set_vec  = {tgt_stall_set, q_fill};
    assign clr_vec  = {tgt_stall_clr, q_drain};

    stall_tracker #(.NC(NUM_CAUSE), .STAT_W(STAT_W)) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .mask    (block_mask),
        .blocked (cpu_blocked),
        .evt_cnt (stall_events),
        .cyc_cnt (stall_cycles)
    );

    miss_countdown #(.LIMIT(MISS_LIMIT)) u_limit (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_event (miss_event),
        .hit        (miss_limit_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q         <= '0;
            resp_valid    <= 1'b0;
            resp_err      <= 1'b0;
            resp_sel      <= 1'b0;
            resp_slot     <= '0;
            resp_seq      <= '0;
            resp_addr     <= '0;
            resp_len      <= '0;
            bus_req_valid <= 1'b0;
            bus_req_cause <= BUSC_MISS;
        end else begin
            resp_valid <= alloc_valid;
            resp_err   <= alloc_valid && !accepted;
            resp_sel   <= alloc_sel;
            resp_slot  <= accepted ? q_grant[alloc_sel] : '0;
            resp_seq   <= seq_q;
            if (accepted) seq_q <= seq_q + SEQ_W'(1);
            if (!alloc_sel) begin
                resp_addr <= alloc_addr & LINE_MASK;
                resp_len  <= LEN_W'(BLK_BYTES);
            end else begin
                resp_addr <= alloc_addr;
                resp_len  <= alloc_size;
            end
            bus_req_valid <= !retry_pending &&
                             ((accepted && alloc_want_bus) || pf_bus_req);
            if (accepted && alloc_want_bus)
                bus_req_cause <= alloc_sel ? BUSC_WB : BUSC_MISS;
            else
                bus_req_cause <= BUSC_PF;
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> (seq_q == $past(seq_q) + SEQ_W'(1))); // R3
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accepted |=> $stable(seq_q)); // R3
    AST_BUS_QUIET_ON_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pending |=> !bus_req_valid); // R10
    AST_MISS_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_err && !resp_sel) |-> (resp_addr[OFF_W-1:0] == '0)); // R4

endmodule

// File: tb/cache_admit_ctrl_tb.sv
module cache_admit_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        err;
        logic        sel;
        logic [1:0]  slot;
        logic [7:0]  seq;
        logic [31:0] addr;
        logic [7:0]  len;
        logic        bus;
        logic [1:0]  bcause;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, alloc_sel = 0, alloc_want_bus = 0;
    logic [31:0] alloc_addr = '0;
    logic [7:0]  alloc_size = '0;
    logic svc_valid = 0, svc_sel = 0;
    logic [1:0] svc_slot = '0;
    logic tgt_stall_set = 0, tgt_stall_clr = 0, pf_bus_req = 0, retry_pending = 0, miss_event = 0;
    logic resp_valid, resp_err, resp_sel, bus_req_valid, cpu_blocked, miss_limit_hit;
    logic [1:0] resp_slot, bus_req_cause;
    logic [7:0] resp_seq, resp_len;
    logic [31:0] resp_addr;
    logic [2:0] block_mask;
    logic [2:0][15:0] stall_events, stall_cycles;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, drv_edge = 0, exp_seq = 0;
    int set_edge = 0;
    int exp_evt[3] = '{0, 0, 0};
    int exp_cyc[3] = '{0, 0, 0};
    exp_t sb[$];

    cache_admit_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_sel(alloc_sel),
        .alloc_addr(alloc_addr), .alloc_size(alloc_size), .alloc_want_bus(alloc_want_bus),
        .svc_valid(svc_valid), .svc_sel(svc_sel), .svc_slot(svc_slot),
        .tgt_stall_set(tgt_stall_set), .tgt_stall_clr(tgt_stall_clr),
        .pf_bus_req(pf_bus_req), .retry_pending(retry_pending), .miss_event(miss_event),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_sel(resp_sel),
        .resp_slot(resp_slot), .resp_seq(resp_seq), .resp_addr(resp_addr),
        .resp_len(resp_len), .bus_req_valid(bus_req_valid), .bus_req_cause(bus_req_cause),
        .cpu_blocked(cpu_blocked), .block_mask(block_mask), .stall_events(stall_events),
        .stall_cycles(stall_cycles), .miss_limit_hit(miss_limit_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // monitor: pops one expected response per resp_valid
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R2", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(resp_err == e.err, "R2", "resp_err", resp_err, e.err);
                if (!e.err) begin
                    chk(resp_slot == e.slot, "R2", "resp_slot", resp_slot, e.slot);
                    chk(resp_seq == e.seq, "R3", "resp_seq", resp_seq, e.seq);
                    chk(resp_addr == e.addr, "R4", "resp_addr", resp_addr, e.addr);
                    chk(resp_len == e.len, "R4", "resp_len", resp_len, e.len);
                end
                chk(bus_req_valid == e.bus, "R10", "bus_req_valid", bus_req_valid, e.bus);
                if (e.bus)
                    chk(bus_req_cause == e.bcause, "R10", "bus_req_cause", bus_req_cause, e.bcause);
            end
        end
    end

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic alloc(input logic sel, input logic [31:0] addr, input logic [7:0] size,
                         input logic bus, input logic tset, input logic exp_err,
                         input logic [1:0] exp_slot);
        exp_t e;
        e.err    = exp_err;
        e.sel    = sel;
        e.slot   = exp_slot;
        e.seq    = 8'(exp_seq);
        e.addr   = sel ? addr : (addr & 32'hFFFF_FFF0);
        e.len    = sel ? size : 8'd16;
        e.bus    = !retry_pending && ((!exp_err && bus) || pf_bus_req);
        e.bcause = (!exp_err && bus) ? {1'b0, sel} : 2'd2;
        if (!exp_err) exp_seq++;
        sb.push_back(e);
        alloc_valid = 1; alloc_sel = sel; alloc_addr = addr; alloc_size = size;
        alloc_want_bus = bus; tgt_stall_set = tset;
        drv_edge = cyc + 1;
        @(posedge clk); #1;
        alloc_valid = 0; alloc_want_bus = 0; tgt_stall_set = 0;
    endtask

    task automatic pulse(input logic sv, input logic sel, input logic [1:0] slot,
                         input logic tset, input logic tclr);
        svc_valid = sv; svc_sel = sel; svc_slot = slot;
        tgt_stall_set = tset; tgt_stall_clr = tclr;
        drv_edge = cyc + 1;
        @(posedge clk); #1;
        svc_valid = 0; tgt_stall_set = 0; tgt_stall_clr = 0;
    endtask

    task automatic chk_stall(input string req);
        for (int c = 0; c < 3; c++) begin
            chk(stall_events[c] == 16'(exp_evt[c]), req, $sformatf("stall_events[%0d]", c),
                stall_events[c], exp_evt[c]);
            chk(stall_cycles[c] == 16'(exp_cyc[c]), req, $sformatf("stall_cycles[%0d]", c),
                stall_cycles[c], exp_cyc[c]);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        chk(0, "R1", "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        settle();
        // R1: reset state
        chk(cpu_blocked == 0, "R1", "cpu_blocked", cpu_blocked, 0);
        chk(block_mask == 0, "R1", "block_mask", block_mask, 0);
        chk(resp_valid == 0 && bus_req_valid == 0 && miss_limit_hit == 0, "R1", "pulses",
            {resp_valid, bus_req_valid, miss_limit_hit}, 0);
        chk_stall("R1");

        alloc(0, 32'h1234, 0, 1, 0, 0, 2'd0);     // R4 aligned, R10 cause 0
        alloc(1, 32'h2005, 3, 1, 0, 0, 2'd0);     // R3 shared seq, R10 cause 1
        alloc(0, 32'h0040, 0, 0, 0, 0, 2'd1);
        pulse(1, 0, 2'd3, 0, 0);                  // R6: free slot in service, ignored
        alloc(0, 32'h0080, 0, 0, 0, 0, 2'd2);     // R6: slot 3 still free
        settle();
        chk(block_mask == 3'b000, "R6", "mask after ignored release", block_mask, 0);

        retry_pending = 1;
        alloc(0, 32'h009F, 0, 1, 0, 0, 2'd3);     // fills miss queue, R10 suppressed
        set_edge = drv_edge;
        retry_pending = 0;
        settle();
        exp_evt[0]++;
        chk(cpu_blocked == 1, "R7", "cpu_blocked after fill", cpu_blocked, 1);
        chk(block_mask == 3'b001, "R5", "mask after fill", block_mask, 3'b001);
        chk_stall("R7");

        alloc(0, 32'h0100, 0, 1, 0, 1, 2'd0);     // R2: full queue rejects
        pulse(0, 0, 0, 1, 0);                     // set cause 2
        pulse(0, 0, 0, 1, 0);                     // R9 redundant set
        settle();
        chk(block_mask == 3'b101, "R9", "mask after redundant set", block_mask, 3'b101);
        chk_stall("R9");
        pulse(0, 0, 0, 0, 1);
        pulse(0, 0, 0, 0, 1);                     // R9 redundant clear
        settle();
        chk(block_mask == 3'b001 && cpu_blocked == 1, "R9", "mask after clears",
            {cpu_blocked, block_mask}, 4'b1001);
        chk_stall("R9");

        pulse(1, 0, 2'd2, 0, 0);                  // R6 release from full queue
        exp_cyc[0] += drv_edge - set_edge;
        settle();
        chk(cpu_blocked == 0 && block_mask == 0, "R6", "unblocked",
            {cpu_blocked, block_mask}, 0);
        chk_stall("R8");

        alloc(0, 32'h0200, 0, 0, 0, 0, 2'd2);     // R2 lowest free is slot 2
        set_edge = drv_edge;
        exp_evt[0]++;
        pulse(1, 0, 2'd0, 1, 0);                  // hand-off: cause 0 -> cause 2
        settle();
        chk(cpu_blocked == 1 && block_mask == 3'b100, "R8", "hand-off",
            {cpu_blocked, block_mask}, 4'b1100);
        pulse(0, 0, 0, 0, 1);
        exp_cyc[2] += drv_edge - set_edge;        // R8 charged to the releasing cause
        settle();
        chk_stall("R8");

        alloc(0, 32'h0300, 0, 0, 1, 0, 2'd0);     // R12 fill + cause 2 together
        set_edge = drv_edge;
        exp_evt[0]++;
        settle();
        chk(block_mask == 3'b101, "R12", "double set mask", block_mask, 3'b101);
        chk_stall("R12");
        pulse(1, 0, 2'd1, 0, 1);                  // R12 both clear together
        exp_cyc[0] += drv_edge - set_edge;
        settle();
        chk(cpu_blocked == 0, "R12", "cpu_blocked", cpu_blocked, 0);
        chk_stall("R12");

        alloc(1, 32'h3001, 8, 0, 0, 0, 2'd1);
        alloc(1, 32'h3002, 8, 0, 0, 0, 2'd2);
        alloc(1, 32'h3003, 8, 0, 0, 0, 2'd3);     // R5 fills write buffer
        set_edge = drv_edge;
        exp_evt[1]++;
        settle();
        chk(block_mask == 3'b010, "R5", "wb full mask", block_mask, 3'b010);
        pulse(1, 1, 2'd0, 0, 0);
        exp_cyc[1] += drv_edge - set_edge;
        settle();
        chk_stall("R8");

        pulse(0, 0, 0, 0, 0);
        pf_bus_req = 1;
        pulse(0, 0, 0, 0, 0);
        pf_bus_req = 0;
        settle();
        chk(bus_req_valid == 1 && bus_req_cause == 2, "R10", "prefetch request",
            {bus_req_valid, bus_req_cause}, 3'b110);
        pf_bus_req = 1; retry_pending = 1;
        pulse(0, 0, 0, 0, 0);
        pf_bus_req = 0; retry_pending = 0;
        settle();
        chk(bus_req_valid == 0, "R10", "prefetch under retry", bus_req_valid, 0);
        pf_bus_req = 1;
        alloc(0, 32'h0400, 0, 1, 0, 0, 2'd1);     // R10 allocation beats prefetch
        pf_bus_req = 0;
        settle();

        for (int k = 1; k <= 6; k++) begin
            miss_event = 1;
            @(posedge clk); #1;
            miss_event = 0;
            settle();
            chk(miss_limit_hit == (k == 5), "R11", $sformatf("limit after %0d", k),
                miss_limit_hit, (k == 5));
            if (k == 5) begin
                settle();
                chk(miss_limit_hit == 0, "R11", "one-shot", miss_limit_hit, 0);
            end
        end

        settle();
        chk(sb.size() == 0, "R2", "responses outstanding", sb.size(), 0);
        finish_run();
    end

endmodule